// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block sits between a processor core and a pair of external memory ports. It turns instruction-fetch requests and data read or write requests into timed bus cycles on a shared 8-bit address/data port, plus a second port that carries the upper address byte. The clock is the oscillator itself, so every timing figure below is a count of clock cycles. Bus time is cut into six-cycle slots. Each slot opens with a two-cycle pulse on an address-latch strobe, and external logic captures the low address byte from the shared port on that strobe's falling edge.

A fetch that misses internal program memory drives a fetch strobe low for the last three cycles of its slot, and the instruction byte is sampled on the final edge. When the internal-memory enable pin is high and the program counter is below a set limit, the fetch is served internally: the slot still runs, but no external strobe is driven. A data access takes two slots. Its read or write strobe stays low for six cycles, and the address-latch pulse of the second slot is suppressed. Requests are taken only at slot boundaries. Data has priority over fetch, and a one-cycle acknowledge marks the slot that serves each request.

Top module: `extBusSeq`

## Requirements
- R1: After reset, `addrLatch` is high during cycles 0 and 1 of every slot it does not suppress, and low in all other cycles.
- R2: A data access takes 12 cycles, numbered 0 to 11. `addrLatch` does not pulse in cycles 6 and 7, so its rising edges are 6 or 12 cycles apart.
- R3: In an external fetch slot, `adOut` carries `pc[7:0]` with `adOe`=1 in cycles 0 to 2. `fetchStbN` is low in cycles 3 to 5 and the port is released. `adIn` is sampled on the edge that ends cycle 5, and in the next cycle `fetchDone`=1 and `fetchData` holds the sampled byte.
- R4: A fetch is internal when `intRomEn`=1 and `pc` < 8192 (so 8191 is internal and 8192 is external). An internal fetch drives no strobe and does not use the port. `fetchDone` pulses in the same cycle as for an external fetch, with `fetchFromExt`=0 for an internal fetch and 1 for an external one.
- R5: In a read, `adOut` carries `dataAddrLo` in cycles 0 to 3. `rdStbN` is low in cycles 4 to 9, with `adOe`=0 from cycle 4 on. `adIn` is sampled on the edge that ends cycle 9, and `readData` holds that byte while `dataDone`=1 in cycle 10.
- R6: In a write, `adOut` carries `dataAddrLo` in cycles 0 to 2 and `wrData` in cycles 3 to 10. `wrStbN` is low in cycles 4 to 9. `dataDone`=1 in cycle 10.
- R7: `hiAddr` is `pc[15:8]` in fetch slots. In data slots it is `ptrHi` when `usePtr`=1 and `portHi` when `usePtr`=0. In idle slots it follows `portHi`. All request arguments are captured when the request is accepted, and later changes to them have no effect on the running access.
- R8: Requests are taken only on the edge that ends a slot. If `dataReq` and `fetchReq` are both high, the data request wins and the fetch waits. `fetchAck` or `dataAck` is high in cycle 0 of the slot that serves the request.
- R9: While `rst` is high, `addrLatch`=0 and `fetchStbN`, `rdStbN` and `wrStbN` are all 1. `adOe`, `fetchDone`, `dataDone`, `fetchAck` and `dataAck` are all 0.
- R10: No two of `fetchStbN`, `rdStbN` and `wrStbN` are ever low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| fetchReq | input | 1 | Fetch request, held until fetchAck |
| pc | input | 16 | Fetch address |
| intRomEn | input | 1 | Internal program memory enable pin |
| fetchAck | output | 1 | Fetch accepted (cycle 0 of its slot) |
| fetchDone | output | 1 | Fetch complete, one cycle |
| fetchData | output | 8 | Instruction byte from the bus |
| fetchFromExt | output | 1 | Last completed fetch used the bus |
| dataReq | input | 1 | Data request, held until dataAck |
| dataWrite | input | 1 | 1 = write, 0 = read |
| usePtr | input | 1 | Upper byte from ptrHi (1) or portHi (0) |
| dataAddrLo | input | 8 | Data address low byte |
| ptrHi | input | 8 | Pointer upper byte |
| portHi | input | 8 | Port latch upper byte |
| wrData | input | 8 | Write data |
| dataAck | output | 1 | Data request accepted |
| dataDone | output | 1 | Data access complete, one cycle |
| readData | output | 8 | Byte captured on a read |
| addrLatch | output | 1 | Address latch strobe, active high |
| fetchStbN | output | 1 | External fetch strobe, active low |
| rdStbN | output | 1 | Read strobe, active low |
| wrStbN | output | 1 | Write strobe, active low |
| adOut | output | 8 | Shared port drive value |
| adOe | output | 1 | Shared port output enable |
| adIn | input | 8 | Shared port input |
| hiAddr | output | 8 | Upper address port |

## Verification
The case of most interest is a fetch request and a data request reaching the slot boundary in the same cycle. The bench raises both in the same cycle, and also raises a new fetch while a data access is still running. It judges the outcome by requiring `dataAck` first, a suppressed latch pulse, and `fetchAck` only after the 12-cycle access has ended. A second collision happens at every fetch boundary: the instruction byte is captured on the same edge that accepts the next request, and the bench changes `adIn` every cycle so that a capture one edge early or late shows up as a wrong byte.

// File: rtl/extBusSeqPkg.sv
package extBusSeqPkg;

  localparam int SLOT_CYC = 6;
  localparam int ALE_CYC  = 2;
  localparam int FSTB_CYC = 3;
  localparam int DSTB_CYC = 6;
  localparam int PH_W     = $clog2(2 * SLOT_CYC);

  typedef logic [PH_W-1:0] phase_t;

  localparam phase_t PH_ALE_LAST   = phase_t'(ALE_CYC - 1);
  localparam phase_t PH_ADDR_LAST  = phase_t'(ALE_CYC);
  localparam phase_t PH_FSTB_FIRST = phase_t'(ALE_CYC + 1);
  localparam phase_t PH_FSTB_LAST  = phase_t'(ALE_CYC + FSTB_CYC);
  localparam phase_t PH_SLOT_LAST  = phase_t'(SLOT_CYC - 1);
  localparam phase_t PH_WDAT_FIRST = phase_t'(ALE_CYC + 1);
  localparam phase_t PH_DSTB_FIRST = phase_t'(ALE_CYC + 2);
  localparam phase_t PH_DSTB_LAST  = phase_t'(ALE_CYC + 1 + DSTB_CYC);
  localparam phase_t PH_WDAT_LAST  = phase_t'(ALE_CYC + 2 + DSTB_CYC);
  localparam phase_t PH_DATA_LAST  = phase_t'(2 * SLOT_CYC - 1);

  typedef enum logic [2:0] {
    K_IDLE, K_FINT, K_FEXT, K_RD, K_WR
  } slotKind_e;

  typedef enum logic [1:0] {
    AD_NONE, AD_PCLO, AD_ADDR, AD_WDAT
  } adSrc_e;

  typedef enum logic [1:0] {
    HI_LIVE, HI_PC, HI_DATA
  } hiSrc_e;

  typedef struct packed {
    logic   loadFetch;
    logic   loadData;
    adSrc_e adSrc;
    hiSrc_e hiSrc;
    logic   capFetch;
    logic   fetchExt;
    logic   capRead;
    logic   dataEnd;
  } seqStb_t;

endpackage

// File: rtl/extBusSeqCtrl.sv
module extBusSeqCtrl
  import extBusSeqPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int INT_LIMIT = 8192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetchReq,
  input  logic              dataReq,
  input  logic              dataWrite,
  input  logic              intRomEn,
  input  logic [ADDR_W-1:0] pc,
  output logic              addrLatch,
  output logic              fetchStbN,
  output logic              rdStbN,
  output logic              wrStbN,
  output logic              fetchAck,
  output logic              dataAck,
  output seqStb_t           stb
);

  localparam logic [ADDR_W:0] LIMIT_V = (ADDR_W + 1)'(INT_LIMIT);

  phase_t    phase;
  slotKind_e kind;
  logic      isData;
  logic      isFetch;
  logic      slotEnd;
  logic      intHit;
  logic      inDstb;

  assign isData  = (kind == K_RD) || (kind == K_WR);
  assign isFetch = (kind == K_FINT) || (kind == K_FEXT);
  assign slotEnd = isData ? (phase == PH_DATA_LAST) : (phase == PH_SLOT_LAST);
  assign intHit  = intRomEn && ({1'b0, pc} < LIMIT_V);
  assign inDstb  = (phase >= PH_DSTB_FIRST) && (phase <= PH_DSTB_LAST);

  // slot sequencing: decisions only at a slot boundary, data before fetch
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_SLOT_LAST;
      kind  <= K_IDLE;
    end else if (slotEnd) begin
      phase <= '0;
      if (dataReq)       kind <= dataWrite ? K_WR : K_RD;
      else if (fetchReq) kind <= intHit ? K_FINT : K_FEXT;
      else               kind <= K_IDLE;
    end else begin
      phase <= phase + phase_t'(1);
    end
  end

  // pin strobes, decoded from registered state only
  assign addrLatch = (phase <= PH_ALE_LAST) && !rst;
  assign fetchStbN = !((kind == K_FEXT) && (phase >= PH_FSTB_FIRST) && (phase <= PH_FSTB_LAST));
  assign rdStbN    = !((kind == K_RD) && inDstb);
  assign wrStbN    = !((kind == K_WR) && inDstb);
  assign fetchAck  = isFetch && (phase == '0);
  assign dataAck   = isData && (phase == '0);

  // strobe bundle for the datapath
  always_comb begin
    stb.loadFetch = slotEnd && !dataReq && fetchReq;
    stb.loadData  = slotEnd && dataReq;
    stb.adSrc     = AD_NONE;
    unique case (kind)
      K_FEXT: if (phase <= PH_ADDR_LAST) stb.adSrc = AD_PCLO;
      K_RD:   if (phase < PH_DSTB_FIRST) stb.adSrc = AD_ADDR;
      K_WR: begin
        if (phase <= PH_ADDR_LAST) stb.adSrc = AD_ADDR;
        else if ((phase >= PH_WDAT_FIRST) && (phase <= PH_WDAT_LAST)) stb.adSrc = AD_WDAT;
      end
      default: stb.adSrc = AD_NONE;
    endcase
    stb.hiSrc    = isFetch ? HI_PC : (isData ? HI_DATA : HI_LIVE);
    stb.capFetch = isFetch && (phase == PH_SLOT_LAST);
    stb.fetchExt = (kind == K_FEXT);
    stb.capRead  = (kind == K_RD) && (phase == PH_DSTB_LAST);
    stb.dataEnd  = isData && (phase == PH_DSTB_LAST);
  end

  // checker state: latch pulse spacing and data strobe width
  logic         aleQ;
  logic         aleSeen;
  logic [4:0]   aleGap;
  phase_t       dLowCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      aleQ    <= 1'b0;
      aleSeen <= 1'b0;
      aleGap  <= '0;
      dLowCnt <= '0;
    end else begin
      aleQ <= addrLatch;
      if (addrLatch && !aleQ) begin
        aleGap  <= 5'd1;
        aleSeen <= 1'b1;
      end else if (aleGap != 5'd31) begin
        aleGap <= aleGap + 5'd1;
      end
      if (!rdStbN || !wrStbN) dLowCnt <= dLowCnt + phase_t'(1);
      else                    dLowCnt <= '0;
    end
  end

  a_r1_ale_width: assert property (@(posedge clk) disable iff (rst)
    $fell(addrLatch) |-> ($past(addrLatch, 2) && !$past(addrLatch, 3)));

  a_r2_ale_spacing: assert property (@(posedge clk) disable iff (rst)
    (addrLatch && !aleQ && aleSeen) |->
      ((aleGap == 5'(SLOT_CYC)) || (aleGap == 5'(2 * SLOT_CYC))));

  a_r3_fstb_after_ale: assert property (@(posedge clk) disable iff (rst)
    $fell(fetchStbN) |-> (!$past(addrLatch) && $past(addrLatch, 2)));

  a_r3_fstb_width: assert property (@(posedge clk) disable iff (rst)
    $rose(fetchStbN) |-> (!$past(fetchStbN, 3) && $past(fetchStbN, 4)));

  a_r5_dstb_width: assert property (@(posedge clk) disable iff (rst)
    (rdStbN && wrStbN && (dLowCnt != '0)) |-> (dLowCnt == phase_t'(DSTB_CYC)));

endmodule

// File: rtl/extBusSeqPath.sv
module extBusSeqPath
  import extBusSeqPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  seqStb_t                  stb,
  input  logic [ADDR_W-1:0]        pc,
  input  logic                     usePtr,
  input  logic [DATA_W-1:0]        dataAddrLo,
  input  logic [ADDR_W-DATA_W-1:0] ptrHi,
  input  logic [ADDR_W-DATA_W-1:0] portHi,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [DATA_W-1:0]        adIn,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  output logic [ADDR_W-DATA_W-1:0] hiAddr,
  output logic                     fetchDone,
  output logic [DATA_W-1:0]        fetchData,
  output logic                     fetchFromExt,
  output logic                     dataDone,
  output logic [DATA_W-1:0]        readData
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] pcLat;
  logic [DATA_W-1:0] addrLat;
  logic [HI_W-1:0]   dataHiLat;
  logic [DATA_W-1:0] wdLat;

  // request arguments, captured at acceptance
  always_ff @(posedge clk) begin
    if (rst) begin
      pcLat     <= '0;
      addrLat   <= '0;
      dataHiLat <= '0;
      wdLat     <= '0;
    end else begin
      if (stb.loadFetch) pcLat <= pc;
      if (stb.loadData) begin
        addrLat   <= dataAddrLo;
        dataHiLat <= usePtr ? ptrHi : portHi;
        wdLat     <= wrData;
      end
    end
  end

  // shared port drive
  always_comb begin
    unique case (stb.adSrc)
      AD_PCLO: adOut = pcLat[DATA_W-1:0];
      AD_ADDR: adOut = addrLat;
      AD_WDAT: adOut = wdLat;
      default: adOut = '0;
    endcase
  end
  assign adOe = (stb.adSrc != AD_NONE);

  // upper address port
  always_comb begin
    unique case (stb.hiSrc)
      HI_PC:   hiAddr = pcLat[ADDR_W-1:DATA_W];
      HI_DATA: hiAddr = dataHiLat;
      default: hiAddr = portHi;
    endcase
  end

  // result capture
  always_ff @(posedge clk) begin
    if (rst) begin
      fetchDone    <= 1'b0;
      fetchData    <= '0;
      fetchFromExt <= 1'b0;
      dataDone     <= 1'b0;
      readData     <= '0;
    end else begin
      fetchDone <= stb.capFetch;
      dataDone  <= stb.dataEnd;
      if (stb.capFetch) fetchFromExt <= stb.fetchExt;
      if (stb.capFetch && stb.fetchExt) fetchData <= adIn;
      if (stb.capRead) readData <= adIn;
    end
  end

  a_r6_wdata_stable: assert property (@(posedge clk) disable iff (rst)
    ((stb.adSrc == AD_WDAT) && $past(stb.adSrc == AD_WDAT)) |-> $stable(adOut));

  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    fetchDone |=> !fetchDone);

  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    dataDone |=> !dataDone);

endmodule

// File: rtl/extBusSeq.sv
module extBusSeq
  import extBusSeqPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int INT_LIMIT = 8192
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fetchReq,
  input  logic [ADDR_W-1:0]        pc,
  input  logic                     intRomEn,
  output logic                     fetchAck,
  output logic                     fetchDone,
  output logic [DATA_W-1:0]        fetchData,
  output logic                     fetchFromExt,
  input  logic                     dataReq,
  input  logic                     dataWrite,
  input  logic                     usePtr,
  input  logic [DATA_W-1:0]        dataAddrLo,
  input  logic [ADDR_W-DATA_W-1:0] ptrHi,
  input  logic [ADDR_W-DATA_W-1:0] portHi,
  input  logic [DATA_W-1:0]        wrData,
  output logic                     dataAck,
  output logic                     dataDone,
  output logic [DATA_W-1:0]        readData,
  output logic                     addrLatch,
  output logic                     fetchStbN,
  output logic                     rdStbN,
  output logic                     wrStbN,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  input  logic [DATA_W-1:0]        adIn,
  output logic [ADDR_W-DATA_W-1:0] hiAddr
);

  seqStb_t stb;

  extBusSeqCtrl #(.ADDR_W(ADDR_W), .INT_LIMIT(INT_LIMIT)) uCtrl (
    .clk(clk), .rst(rst),
    .fetchReq(fetchReq), .dataReq(dataReq), .dataWrite(dataWrite),
    .intRomEn(intRomEn), .pc(pc),
    .addrLatch(addrLatch), .fetchStbN(fetchStbN),
    .rdStbN(rdStbN), .wrStbN(wrStbN),
    .fetchAck(fetchAck), .dataAck(dataAck),
    .stb(stb)
  );

  extBusSeqPath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uPath (
    .clk(clk), .rst(rst), .stb(stb),
    .pc(pc), .usePtr(usePtr), .dataAddrLo(dataAddrLo),
    .ptrHi(ptrHi), .portHi(portHi), .wrData(wrData), .adIn(adIn),
    .adOut(adOut), .adOe(adOe), .hiAddr(hiAddr),
    .fetchDone(fetchDone), .fetchData(fetchData), .fetchFromExt(fetchFromExt),
    .dataDone(dataDone), .readData(readData)
  );

  a_r10_one_strobe: assert property (@(posedge clk) disable iff (rst)
    ((fetchStbN ? 1'b0 : 1'b1) + (rdStbN ? 1'b0 : 1'b1) + (wrStbN ? 1'b0 : 1'b1)) <= 2'd1);

  a_r5_float_on_read: assert property (@(posedge clk) disable iff (rst)
    !rdStbN |-> !adOe);

  a_r6_drive_on_write: assert property (@(posedge clk) disable iff (rst)
    !wrStbN |-> adOe);

  a_r3_float_on_fetch: assert property (@(posedge clk) disable iff (rst)
    !fetchStbN |-> !adOe);

endmodule

// File: tb/extBusSeq_test.sv
module extBusSeq_test;

  localparam int CLK_PERIOD = 10;
  localparam int STEPS      = 66;

  logic       clk = 1'b0;
  logic       rst;
  logic       fetchReq, intRomEn, dataReq, dataWrite, usePtr;
  logic [15:0] pc;
  logic [7:0] dataAddrLo, ptrHi, portHi, wrData, adIn;
  logic       fetchAck, fetchDone, fetchFromExt, dataAck, dataDone;
  logic [7:0] fetchData, readData, adOut, hiAddr;
  logic       addrLatch, fetchStbN, rdStbN, wrStbN, adOe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  extBusSeq uut (
    .clk(clk), .rst(rst), .fetchReq(fetchReq), .pc(pc), .intRomEn(intRomEn),
    .fetchAck(fetchAck), .fetchDone(fetchDone), .fetchData(fetchData),
    .fetchFromExt(fetchFromExt), .dataReq(dataReq), .dataWrite(dataWrite),
    .usePtr(usePtr), .dataAddrLo(dataAddrLo), .ptrHi(ptrHi), .portHi(portHi),
    .wrData(wrData), .dataAck(dataAck), .dataDone(dataDone), .readData(readData),
    .addrLatch(addrLatch), .fetchStbN(fetchStbN), .rdStbN(rdStbN), .wrStbN(wrStbN),
    .adOut(adOut), .adOe(adOe), .adIn(adIn), .hiAddr(hiAddr)
  );

  // ---------------- behavioural reference ----------------
  // kinds: 0 idle, 1 internal fetch, 2 external fetch, 3 read, 4 write
  int mPos, mKind;
  int mPc, mAddr, mHi, mWd;
  int mFDone, mFData, mExt, mDDone, mRData;

  always @(posedge clk) begin
    if (rst) begin
      mPos <= 5; mKind <= 0;
      mPc <= 0; mAddr <= 0; mHi <= 0; mWd <= 0;
      mFDone <= 0; mFData <= 0; mExt <= 0; mDDone <= 0; mRData <= 0;
    end else begin
      mFDone <= ((mKind == 1 || mKind == 2) && mPos == 5) ? 1 : 0;
      if ((mKind == 1 || mKind == 2) && mPos == 5) mExt <= (mKind == 2) ? 1 : 0;
      if (mKind == 2 && mPos == 5) mFData <= int'(adIn);
      mDDone <= (mKind >= 3 && mPos == 9) ? 1 : 0;
      if (mKind == 3 && mPos == 9) mRData <= int'(adIn);
      if ((mKind >= 3) ? (mPos == 11) : (mPos == 5)) begin
        mPos <= 0;
        if (dataReq) begin
          mKind <= dataWrite ? 4 : 3;
          mAddr <= int'(dataAddrLo);
          mHi   <= usePtr ? int'(ptrHi) : int'(portHi);
          mWd   <= int'(wrData);
        end else if (fetchReq) begin
          mKind <= (intRomEn && int'(pc) < 8192) ? 1 : 2;
          mPc   <= int'(pc);
        end else begin
          mKind <= 0;
        end
      end else begin
        mPos <= mPos + 1;
      end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s at %0t: got %0d expected %0d", tag, $time, got, exp);
    end
  endtask

  task automatic compareAll();
    int eOe, eAd, eHi;
    chk("R1 R2 addrLatch", int'(addrLatch), (mPos < 2) ? 1 : 0);
    chk("R3 fetchStbN", int'(fetchStbN), (mKind == 2 && mPos >= 3 && mPos <= 5) ? 0 : 1);
    chk("R5 rdStbN", int'(rdStbN), (mKind == 3 && mPos >= 4 && mPos <= 9) ? 0 : 1);
    chk("R6 wrStbN", int'(wrStbN), (mKind == 4 && mPos >= 4 && mPos <= 9) ? 0 : 1);
    eOe = 0; eAd = 0;
    if (mKind == 2 && mPos <= 2) begin eOe = 1; eAd = mPc % 256; end
    if (mKind == 3 && mPos <= 3) begin eOe = 1; eAd = mAddr; end
    if (mKind == 4 && mPos <= 2) begin eOe = 1; eAd = mAddr; end
    if (mKind == 4 && mPos >= 3 && mPos <= 10) begin eOe = 1; eAd = mWd; end
    chk("R3 R5 R6 adOe", int'(adOe), eOe);
    if (eOe == 1) chk("R3 R5 R6 adOut", int'(adOut), eAd);
    if (mKind == 1 || mKind == 2) eHi = mPc / 256;
    else if (mKind >= 3)          eHi = mHi;
    else                          eHi = int'(portHi);
    chk("R7 hiAddr", int'(hiAddr), eHi);
    chk("R8 fetchAck", int'(fetchAck), ((mKind == 1 || mKind == 2) && mPos == 0) ? 1 : 0);
    chk("R8 dataAck", int'(dataAck), (mKind >= 3 && mPos == 0) ? 1 : 0);
    chk("R3 fetchDone", int'(fetchDone), mFDone);
    chk("R4 fetchFromExt", int'(fetchFromExt), mExt);
    if (mFDone == 1 && mExt == 1) chk("R3 fetchData", int'(fetchData), mFData);
    chk("R5 R6 dataDone", int'(dataDone), mDDone);
    if (mDDone == 1) chk("R5 readData", int'(readData), mRData);
    chk("R10 strobe overlap", int'(!fetchStbN) + int'(!rdStbN) + int'(!wrStbN) > 1 ? 1 : 0, 0);
  endtask

  task automatic finish();
    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // ---------------- stimulus ----------------
  task automatic issue(input int i);
    int mode;
    mode = i % 6;
    case (mode)
      0: begin fetchReq = 1; intRomEn = 0; pc = 16'(i * 977 + 3); end
      1: begin fetchReq = 1; intRomEn = 1; pc = (i % 12 == 1) ? 16'd8191 : 16'((i * 131) % 8192); end
      2: begin fetchReq = 1; intRomEn = 1; pc = 16'(8192 + i * 17); end
      3: begin dataReq = 1; dataWrite = 0; usePtr = i[1];
               dataAddrLo = 8'(i * 7 + 1); ptrHi = 8'(i * 3 + 90); portHi = 8'(i * 5 + 11); end
      4: begin dataReq = 1; dataWrite = 1; usePtr = i[1];
               dataAddrLo = 8'(i * 9 + 2); ptrHi = 8'(i + 40); portHi = 8'(i * 11);
               wrData = 8'(i * 29 + 1); end
      default: begin
        fetchReq = 1; intRomEn = i[1]; pc = 16'(i * 4099);
        dataReq = 1; dataWrite = i[0]; usePtr = i[2];
        dataAddrLo = 8'(i * 13); ptrHi = 8'(i * 7); portHi = 8'(i * 2 + 1);
        wrData = 8'(255 - i);
      end
    endcase
  endtask

  initial begin
    int stepIdx, gap, cyc;
    rst = 1; fetchReq = 0; dataReq = 0; dataWrite = 0; usePtr = 0; intRomEn = 0;
    pc = 0; dataAddrLo = 0; ptrHi = 0; portHi = 8'h5A; wrData = 0; adIn = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 addrLatch", int'(addrLatch), 0);
    chk("R9 fetchStbN", int'(fetchStbN), 1);
    chk("R9 rdStbN", int'(rdStbN), 1);
    chk("R9 wrStbN", int'(wrStbN), 1);
    chk("R9 adOe", int'(adOe), 0);
    chk("R9 done/ack", int'(fetchDone) + int'(dataDone) + int'(fetchAck) + int'(dataAck), 0);
    rst = 0;
    stepIdx = 0; gap = 0; cyc = 0;
    while (stepIdx < STEPS || fetchReq || dataReq || gap < 30) begin
      @(negedge clk);
      compareAll();
      // R7: arguments change after acceptance; the running access must not follow
      if (fetchAck) begin fetchReq = 0; pc = 16'(pc * 3 + 7); intRomEn = ~intRomEn; end
      if (dataAck) begin
        dataReq = 0; dataAddrLo = ~dataAddrLo; ptrHi = ptrHi + 8'd1;
        wrData = wrData ^ 8'hC3; usePtr = ~usePtr;
      end
      portHi = 8'(cyc * 5);
      if (!fetchReq && !dataReq) begin
        if (stepIdx < STEPS) begin
          if (gap >= stepIdx % 3) begin issue(stepIdx); stepIdx++; gap = 0; end
          else gap++;
        end else begin
          gap++;
        end
      end
      adIn = 8'(cyc * 37 + 5);
      cyc++;
    end
    finish();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish();
    end
  end

endmodule